// File: doc/BRIEF.md
# Keyed Countdown Watchdog Timer

This block is a 32-bit countdown watchdog that sits behind a small register bus. The bus is word-addressed and has separate read and write strobes. Software sets a reload value and arms the timer through a control word. To keep the system alive, software must write a fixed 16-bit key to a dedicated restart location before the count runs out. The count can decrement once per peripheral clock cycle, or once per microsecond. The microsecond tick comes from a divide-by-24 prescaler on the 24 MHz peripheral clock.

When an armed countdown is at zero and the next tick arrives, the block expires. On expiry it sets a sticky timeout flag and reloads the count, then keeps running. Depending on the control bits, it also drives a one-cycle reset request, a one-cycle external reset request, a reset-scope indicator and a level interrupt. The control word has a guard: a write lands only if it flips the enable bit. Every other control write is dropped.

Top module: `wdg_top`

## Requirements
- R1: After a synchronous reset, the count and the reload registers read 0x03EF1480. The control, status and spare-storage registers read 0. All four event outputs are low.
- R2: The reload register (word 1) and the spare-storage register (word 6) return the last value written to them.
- R3: A write to the restart register (word 2) whose low 16 bits equal 0x4755 copies the reload value into the count. The upper bits do not matter. A write with any other low half leaves the count unchanged. A read of word 2 returns 0.
- R4: A write to the control register (word 3) is stored only if its bit 0 differs from the stored enable bit. A write that keeps the enable state leaves the register unchanged. An enabling write also loads the count from the reload value.
- R5: While the enable bit (control bit 0) is clear, the count does not change except through a keyed restart.
- R6: With control bit 4 clear, an enabled count decrements on every clock. With control bit 4 set, it decrements once every 24 clocks. The first decrement comes 24 clocks after the enabling write.
- R7: A tick that finds an enabled count at 0 is an expiry. The expiry reloads the count and sets status bit 0 (word 4). A reload value of N therefore gives N+1 ticks between expiries.
- R8: On an expiry, the reset output pulses high for exactly one cycle if control bit 1 is set. The full-chip output goes high in that same cycle only if control bit 5 is also set. The external reset output pulses for one cycle if control bit 3 is set. When these bits are clear, the outputs stay low.
- R9: On an expiry, the interrupt output rises if control bit 2 is set. It stays high until any write to the clear register (word 5). That write also clears status bit 0.
- R10: Writes to the count register (word 0) and to the unmapped word 7 have no effect. Word 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid combinationally while the read strobe is high, 0 otherwise |
| wdg_rst_o | output | 1 | One-cycle reset request on expiry |
| wdg_full_chip_o | output | 1 | High with the reset request when full-chip scope is selected |
| wdg_ext_o | output | 1 | One-cycle external reset request on expiry |
| wdg_irq_o | output | 1 | Level interrupt, held until cleared |

## Verification
A corrupted count becomes visible on the next read of word 0. In the fast-tick mode, it also moves the expiry pulse by the same number of cycles. A prescaler phase error shows up only as a shift in where the 24-cycle decrement steps fall. For this reason, the bench samples the count one cycle before and one cycle after the first slow step. A control register that took a write it should have refused, or a flag that failed to stick, shows up at the next control or status read. A flag fault can also show up at once as a missing or extra interrupt level.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned WDG_DW = 32;
    localparam int unsigned WDG_KEY_W = 16;
    localparam logic [WDG_KEY_W-1:0] WDG_RESTART_KEY = 16'h4755;

    localparam logic [2:0] WOFS_COUNT   = 3'd0;
    localparam logic [2:0] WOFS_RELOAD  = 3'd1;
    localparam logic [2:0] WOFS_RESTART = 3'd2;
    localparam logic [2:0] WOFS_CTRL    = 3'd3;
    localparam logic [2:0] WOFS_STATUS  = 3'd4;
    localparam logic [2:0] WOFS_CLEAR   = 3'd5;
    localparam logic [2:0] WOFS_SPARE   = 3'd6;

    typedef struct packed {
        logic [25:0] spare_bits;
        logic        full_chip;
        logic        slow_tick;
        logic        ext_en;
        logic        irq_en;
        logic        rst_en;
        logic        enable;
    } wdg_ctrl_t;

    typedef struct packed {
        logic rst;
        logic full_chip;
        logic ext;
    } wdg_fire_t;

    function automatic logic key_match(input logic [WDG_KEY_W-1:0] low_half);
        return low_half == WDG_RESTART_KEY;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 3,
    parameter logic [31:0] RESET_LOAD = 32'h03EF1480
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WDG_DW-1:0] wdata_i,
    input  logic [WDG_DW-1:0] count_i,
    input  logic              status_i,
    output logic [WDG_DW-1:0] rdata_o,
    output logic [WDG_DW-1:0] reload_o,
    output wdg_ctrl_t         ctrl_o,
    output logic              load_o,
    output logic              clear_o
);
    logic [WDG_DW-1:0] reload_q;
    logic [WDG_DW-1:0] spare_q;
    wdg_ctrl_t         ctrl_q;
    logic [2:0]        word;
    logic              ctrl_take;
    logic              restart_hit;

    assign word        = 3'(addr_i);
    assign ctrl_take   = wr_i && (word == WOFS_CTRL) && (wdata_i[0] != ctrl_q.enable);
    assign restart_hit = wr_i && (word == WOFS_RESTART) && key_match(wdata_i[WDG_KEY_W-1:0]);
    assign load_o      = restart_hit || (ctrl_take && wdata_i[0]);
    assign clear_o     = wr_i && (word == WOFS_CLEAR);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            reload_q <= RESET_LOAD;
            spare_q  <= '0;
            ctrl_q   <= '0;
        end else begin
            if (wr_i && word == WOFS_RELOAD) reload_q <= wdata_i;
            if (wr_i && word == WOFS_SPARE)  spare_q  <= wdata_i;
            if (ctrl_take)                   ctrl_q   <= wdg_ctrl_t'(wdata_i);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (word)
                WOFS_COUNT:  rdata_o = count_i;
                WOFS_RELOAD: rdata_o = reload_q;
                WOFS_CTRL:   rdata_o = ctrl_q;
                WOFS_STATUS: rdata_o = {{(WDG_DW-1){1'b0}}, status_i};
                WOFS_SPARE:  rdata_o = spare_q;
                default:     rdata_o = '0;
            endcase
        end
    end

    assign reload_o = reload_q;
    assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int unsigned DIV = 24
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    input  logic slow_i,
    input  logic sync_clr_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;
    logic          wrap;

    assign wrap = (phase_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || sync_clr_i || !enable_i) phase_q <= '0;
        else if (wrap)                        phase_q <= '0;
        else                                  phase_q <= phase_q + 1'b1;
    end

    assign tick_o = enable_i && (slow_i ? wrap : 1'b1);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter logic [31:0] RESET_LOAD = 32'h03EF1480
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [WDG_DW-1:0] reload_i,
    input  logic              tick_i,
    output logic [WDG_DW-1:0] count_o,
    output logic              expire_o
);
    logic [WDG_DW-1:0] count_q;

    assign expire_o = tick_i && !load_i && (count_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i)         count_q <= RESET_LOAD;
        else if (load_i)   count_q <= reload_i;
        else if (expire_o) count_q <= reload_i;
        else if (tick_i)   count_q <= count_q - 1'b1;
    end

    assign count_o = count_q;
endmodule

// File: rtl/wdg_alarm.sv
module wdg_alarm
    import wdg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      expire_i,
    input  logic      clear_i,
    input  wdg_ctrl_t ctrl_i,
    output logic      status_o,
    output logic      irq_o,
    output wdg_fire_t fire_o
);
    logic      status_q;
    logic      irq_q;
    wdg_fire_t fire_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            status_q <= 1'b0;
            irq_q    <= 1'b0;
            fire_q   <= '0;
        end else begin
            if (clear_i)                    status_q <= 1'b0;
            if (expire_i)                   status_q <= 1'b1;
            if (clear_i)                    irq_q    <= 1'b0;
            if (expire_i && ctrl_i.irq_en)  irq_q    <= 1'b1;
            fire_q.rst       <= expire_i && ctrl_i.rst_en;
            fire_q.full_chip <= expire_i && ctrl_i.rst_en && ctrl_i.full_chip;
            fire_q.ext       <= expire_i && ctrl_i.ext_en;
        end
    end

    assign status_o = status_q;
    assign irq_o    = irq_q;
    assign fire_o   = fire_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W       = 3,
    parameter int unsigned PRESCALE_DIV = 24,
    parameter logic [31:0] RESET_LOAD   = 32'h03EF1480
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              wdg_rst_o,
    output logic              wdg_full_chip_o,
    output logic              wdg_ext_o,
    output logic              wdg_irq_o
);
    logic [WDG_DW-1:0] count_q;
    logic [WDG_DW-1:0] reload_q;
    wdg_ctrl_t         ctrl_q;
    logic              status_q;
    logic              load_req;
    logic              clear_req;
    logic              tick;
    logic              expire;
    wdg_fire_t         fire;

    wdg_regs #(.ADDR_W(ADDR_W), .RESET_LOAD(RESET_LOAD)) u_regs (
        .clk_i(clk_i), .rst_i(rst_i),
        .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
        .count_i(count_q), .status_i(status_q),
        .rdata_o(bus_rdata_o), .reload_o(reload_q), .ctrl_o(ctrl_q),
        .load_o(load_req), .clear_o(clear_req)
    );

    wdg_prescale #(.DIV(PRESCALE_DIV)) u_pre (
        .clk_i(clk_i), .rst_i(rst_i),
        .enable_i(ctrl_q.enable), .slow_i(ctrl_q.slow_tick),
        .sync_clr_i(load_req), .tick_o(tick)
    );

    wdg_counter #(.RESET_LOAD(RESET_LOAD)) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i),
        .load_i(load_req), .reload_i(reload_q), .tick_i(tick),
        .count_o(count_q), .expire_o(expire)
    );

    wdg_alarm u_alarm (
        .clk_i(clk_i), .rst_i(rst_i),
        .expire_i(expire), .clear_i(clear_req), .ctrl_i(ctrl_q),
        .status_o(status_q), .irq_o(wdg_irq_o), .fire_o(fire)
    );

    assign wdg_rst_o       = fire.rst;
    assign wdg_full_chip_o = fire.full_chip;
    assign wdg_ext_o       = fire.ext;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [31:0]       count,
    input logic [31:0]       reload,
    input logic [31:0]       ctrl,
    input logic              status,
    input logic              irq,
    input logic              rst_pulse,
    input logic              full_chip
);
    p_restart_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == ADDR_W'(2)) |-> rdata == 32'd0);

    p_key_loads_count_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_W'(2) && wdata[15:0] == 16'h4755) |=> count == $past(reload));

    p_same_enable_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_W'(3) && wdata[0] == ctrl[0]) |=> $stable(ctrl));

    p_idle_count_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[0] && !wr) |=> $stable(count));

    p_pulse_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> $past(ctrl[1]));

    p_scope_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        full_chip |-> rst_pulse);

    p_irq_held_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr && addr == ADDR_W'(5))) |=> irq);

    p_irq_implies_status_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> status);
endmodule

bind wdg_top wdg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk_i), .rst(rst_i), .wr(bus_wr_i), .rd(bus_rd_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .rdata(bus_rdata_o), .count(count_q), .reload(reload_q),
    .ctrl(ctrl_q), .status(status_q), .irq(wdg_irq_o), .rst_pulse(wdg_rst_o),
    .full_chip(wdg_full_chip_o)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
    localparam int unsigned AW = 3;
    localparam logic [31:0] RST_LOAD = 32'h03EF1480;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          o_rst, o_full, o_ext, o_irq;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    wdg_top dut (
        .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wdg_rst_o(o_rst),
        .wdg_full_chip_o(o_full), .wdg_ext_o(o_ext), .wdg_irq_o(o_irq)
    );

    function automatic bit is_key(input logic [31:0] d);
        return d[15:0] == 16'h4755;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] v);
        rd = 1'b1; addr = a;
        #1;
        v = rdata;
        rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, exp_cnt, exp_rel, d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd0, v); check("R1 count", v, RST_LOAD);
        bus_read(3'd1, v); check("R1 reload", v, RST_LOAD);
        bus_read(3'd3, v); check("R1 ctrl", v, 32'd0);
        bus_read(3'd4, v); check("R1 status", v, 32'd0);
        bus_read(3'd6, v); check("R1 spare", v, 32'd0);
        check("R1 outputs", {28'd0, o_rst, o_full, o_ext, o_irq}, 32'd0);

        // R2 storage registers
        d = $urandom(); bus_write(3'd1, d); bus_read(3'd1, v); check("R2 reload", v, d);
        d = $urandom(); bus_write(3'd6, d); bus_read(3'd6, v); check("R2 spare", v, d);

        // R10 count write ignored, word 7 dead
        bus_write(3'd0, 32'h1234_5678); bus_read(3'd0, v); check("R10 count write", v, RST_LOAD);
        bus_write(3'd7, 32'hFFFF_FFFF); bus_read(3'd7, v); check("R10 word7", v, 32'd0);

        // R3 keyed restart, random mix while disabled
        exp_cnt = RST_LOAD;
        exp_rel = d;
        bus_write(3'd1, 32'h0000_0100); exp_rel = 32'h100;
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                exp_rel = $urandom();
                bus_write(3'd1, exp_rel);
            end
            d = $urandom();
            if ($urandom_range(0, 1) == 0) d[15:0] = 16'h4755;
            else if (d[15:0] == 16'h4755) d[0] = ~d[0];
            bus_write(3'd2, d);
            if (is_key(d)) exp_cnt = exp_rel;
            bus_read(3'd0, v); check("R3 restart", v, exp_cnt);
        end
        bus_read(3'd2, v); check("R3 restart read", v, 32'd0);

        // R4 disable-to-disable write dropped; R5 frozen while idle
        bus_write(3'd3, 32'h0000_003E); bus_read(3'd3, v); check("R4 same enable", v, 32'd0);
        bus_read(3'd0, v); repeat (10) @(negedge clk); bus_read(3'd0, v2);
        check("R5 idle frozen", v2, v);

        // R6/R7/R8/R9 fast tick, reload 10, all options on
        bus_write(3'd1, 32'd10);
        bus_write(3'd3, 32'h0000_002F);
        bus_read(3'd0, v); check("R4 enable loads", v, 32'd10);
        repeat (3) @(negedge clk);
        bus_read(3'd0, v); check("R6 fast decrement", v, 32'd7);
        check("R8 no early pulse", {31'd0, o_rst}, 32'd0);
        repeat (8) @(negedge clk);
        check("R8 reset pulse", {31'd0, o_rst}, 32'd1);
        check("R8 full chip", {31'd0, o_full}, 32'd1);
        check("R8 ext pulse", {31'd0, o_ext}, 32'd1);
        check("R9 irq rise", {31'd0, o_irq}, 32'd1);
        bus_read(3'd0, v); check("R7 reload on expiry", v, 32'd10);
        bus_read(3'd4, v); check("R7 status set", v, 32'd1);
        @(negedge clk);
        check("R8 one cycle", {31'd0, o_rst}, 32'd0);
        check("R9 irq held", {31'd0, o_irq}, 32'd1);

        // R4 enabled-to-enabled write dropped
        bus_write(3'd3, 32'h0000_0011); bus_read(3'd3, v); check("R4 keep enable", v, 32'h2F);
        bus_write(3'd3, 32'h0000_0000); bus_read(3'd3, v); check("R4 disable stored", v, 32'd0);
        bus_read(3'd0, v); repeat (7) @(negedge clk); bus_read(3'd0, v2);
        check("R5 stopped", v2, v);
        check("R9 irq before clear", {31'd0, o_irq}, 32'd1);
        bus_write(3'd5, $urandom());
        check("R9 irq cleared", {31'd0, o_irq}, 32'd0);
        bus_read(3'd4, v); check("R9 status cleared", v, 32'd0);

        // R6 slow tick, reload 2, no outputs enabled
        bus_write(3'd1, 32'd2);
        bus_write(3'd3, 32'h0000_0011);
        repeat (23) @(negedge clk);
        bus_read(3'd0, v); check("R6 slow hold", v, 32'd2);
        @(negedge clk);
        bus_read(3'd0, v); check("R6 slow step", v, 32'd1);
        repeat (47) @(negedge clk);
        bus_read(3'd4, v); check("R7 slow no expiry yet", v, 32'd0);
        @(negedge clk);
        bus_read(3'd4, v); check("R7 slow expiry", v, 32'd1);
        bus_read(3'd0, v); check("R7 slow reload", v, 32'd2);
        check("R8 masked", {30'd0, o_rst, o_ext}, 32'd0);
        check("R9 masked irq", {31'd0, o_irq}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule